// File: doc/BRIEF.md
# Byte-Deinterleaving Transmit Gearbox

This block turns wide transmit words into a 16-bit stream that advances on every fast-clock cycle. A word is 128 bits wide in the 1:8 ratio and 64 bits wide in the 1:4 ratio. Each input byte is steered to its own output lane, or to a pair of adjacent lanes in the 1:4 ratio. The lane shift registers then emit the byte's bits, most significant first. The whole design runs in the fast clock domain. The slower word rate appears only as a load enable.

The 16 lanes form four channels of four lanes each. The lanes can act as one 16-bit bus, where channel 0's load enable governs every lane. They can also act as four independent 4-bit channels, each with its own load enable. A load enable comes either from a free-running counter inside the block, which is the default, or from one external enable pin per channel. An external enable must stay high for a whole word period, and the internal counter realigns to it. A sticky flag records enable pulses that are malformed or misaligned.

Top module: `tx_gearbox`

## Requirements
- R1: While `rst_n` is low, `tx_lanes`, `ch_strobe` and `align_err` are all zero. After release, with internal enables, the first load happens on the P-th rising edge, where P is 8 in the 1:8 ratio (`div4_mode`=0) and 4 in the 1:4 ratio (`div4_mode`=1).
- R2: In the 1:8 ratio, lane k (`tx_lanes[k]`) emits byte k (`tx_word[8k+7:8k]`), one bit per cycle, starting with bit 7. Bit 7 appears in the cycle after the load edge.
- R3: In the 1:4 ratio, byte b (`tx_word[8b+7:8b]`, b = 0..7) feeds lanes 2b+1 and 2b. In the j-th cycle after a load (j = 0..3), lane 2b+1 shows bit 7-2j and lane 2b shows bit 6-2j. `tx_word[127:64]` is ignored.
- R4: With internal enables (`ext_en_sel`=0), loads repeat every P cycles. `tx_word` is sampled only on the load edge.
- R5: `ch_strobe[c]` is high for exactly the one cycle in which channel c shows the first bits of a newly loaded word.
- R6: In bus mode (`quad_mode`=0), all four channels load together under channel 0's enable, and `ext_load_en[3:1]` has no effect.
- R7: In channel mode (`quad_mode`=1), channel c (lanes 4c..4c+3) loads only on its own enable, independently of the other channels.
- R8: With external enables (`ext_en_sel`=1), a load happens on the P-th consecutive rising edge at which the enable is high. An enable held high loads every P cycles.
- R9: If an external enable falls before completing P high cycles, no load happens and `align_err` goes high on that edge. It stays high until reset.
- R10: If an external load happens while the internal counter is not at its terminal count, `align_err` is set. The counter restarts from that load, so later internal loads follow at P-cycle spacing from it.
- R11: A lane that is not reloaded emits zeros once its P bit-times are used up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div4_mode | input | 1 | 1 selects the 1:4 ratio (64-bit words), 0 selects 1:8 (128-bit words) |
| quad_mode | input | 1 | 1 selects four independent channels, 0 a single 16-bit bus |
| ext_en_sel | input | 1 | 1 uses the external load enables, 0 the internal counter |
| ext_load_en | input | 4 | Per-channel external load enable |
| tx_word | input | 128 | Parallel transmit word |
| tx_lanes | output | 16 | Serial lane outputs, one bit per lane per cycle |
| ch_strobe | output | 4 | Per-channel marker of the first cycle of a new word |
| align_err | output | 1 | Sticky enable width or alignment error |

## Verification
A load edge shows up one register later. The lane's top bit, the channel strobe and any alignment error all become visible in the cycle that follows that edge. Each further bit follows one cycle after the previous one. The bench advances a reference model on every rising edge, using the same inputs the design sees. It compares every output at the next falling edge, so each result is judged in exactly the cycle it is due. Explicit checks with hand-counted edge numbers pin down the first load, the error edges and the realigned load positions.

// File: rtl/txg_pkg.sv
package txg_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic {
    RATIO_BY8 = 1'b0,
    RATIO_BY4 = 1'b1
  } ratio_e;

  // Spread one half of a byte's bits (upper: 7,5,3,1 / lower: 6,4,2,0)
  // into the top of a lane register, in shift-out order.
  function automatic logic [BYTE_W-1:0] half_spread(input logic [BYTE_W-1:0] b,
                                                   input logic             upper);
    logic [BYTE_W-1:0] r;
    r = '0;
    for (int i = 0; i < BYTE_W/2; i++) begin
      r[BYTE_W-1-i] = upper ? b[BYTE_W-1-2*i] : b[BYTE_W-2-2*i];
    end
    return r;
  endfunction

endpackage

// File: rtl/txg_enable_gen.sv
module txg_enable_gen
  import txg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic div4,
  input  logic ext_sel,
  input  logic en_in,
  output logic ld,
  output logic err_evt
);

  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST_BY8 = CW'(BYTE_W - 1);
  localparam logic [CW-1:0] LAST_BY4 = CW'(BYTE_W/2 - 1);

  ratio_e        ratio;
  logic [CW-1:0] last;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] run_q, run_d;
  logic          tc;
  logic          ext_ld;

  always_comb begin
    ratio  = ratio_e'(div4);
    last   = (ratio == RATIO_BY4) ? LAST_BY4 : LAST_BY8;
    tc     = (cnt_q >= last);
    ext_ld = ext_sel && en_in && (run_q >= last);
    ld     = ext_sel ? ext_ld : tc;

    if (!ext_sel || !en_in || ext_ld) begin
      run_d = '0;
    end else begin
      run_d = run_q + 1'b1;
    end

    err_evt = ext_sel && ((ext_ld && !tc) || (!en_in && (run_q != '0)));

    if (ld || tc) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  // R8: a low external enable can never produce a load
  p_ext_low_no_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel && !en_in) |-> !ld);

  // R10: every load restarts the word counter
  p_cnt_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt_q == '0));

endmodule

// File: rtl/txg_lane_bank.sv
module txg_lane_bank
  import txg_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        div4,
  input  logic                        ld,
  input  logic [LANES*BYTE_W-1:0]     wide_bytes,
  input  logic [(LANES/2)*BYTE_W-1:0] narrow_bytes,
  output logic [LANES-1:0]            lane_bits
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int NB  = i / 2;
    localparam int HI4 = NB*BYTE_W + BYTE_W - 1 - (((i % 2) == 1) ? 0 : 1);
    localparam int HI8 = i*BYTE_W + BYTE_W - 1;

    logic [BYTE_W-1:0] sr_q, sr_d, fill;

    always_comb begin
      if (div4) begin
        fill = half_spread(narrow_bytes[NB*BYTE_W +: BYTE_W], 1'((i % 2) == 1));
      end else begin
        fill = wide_bytes[i*BYTE_W +: BYTE_W];
      end
      sr_d = ld ? fill : {sr_q[BYTE_W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sr_q <= '0;
      end else begin
        sr_q <= sr_d;
      end
    end

    assign lane_bits[i] = sr_q[BYTE_W-1];

    // R2: after a 1:8 load the lane shows its byte's top bit
    p_msb_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && !div4) |=> (lane_bits[i] == $past(wide_bytes[HI8])));

    // R3: after a 1:4 load the lane shows its half's top bit
    p_pair_split_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && div4) |=> (lane_bits[i] == $past(narrow_bytes[HI4])));
  end

endmodule

// File: rtl/tx_gearbox.sv
module tx_gearbox
  import txg_pkg::*;
#(
  parameter int NCH = 4,
  parameter int LPC = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       div4_mode,
  input  logic                       quad_mode,
  input  logic                       ext_en_sel,
  input  logic [NCH-1:0]             ext_load_en,
  input  logic [NCH*LPC*BYTE_W-1:0]  tx_word,
  output logic [NCH*LPC-1:0]         tx_lanes,
  output logic [NCH-1:0]             ch_strobe,
  output logic                       align_err
);

  localparam int OUT_W     = NCH * LPC;
  localparam int CH_WIDE   = LPC * BYTE_W;
  localparam int CH_NARROW = (LPC / 2) * BYTE_W;

  logic [NCH-1:0] ld_own;
  logic [NCH-1:0] ld_eff;
  logic [NCH-1:0] err_evt;
  logic [NCH-1:0] strobe_q, strobe_d;
  logic           err_q, err_d;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic en_c;

    assign en_c = quad_mode ? ext_load_en[c] : ext_load_en[0];

    txg_enable_gen u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .div4    (div4_mode),
      .ext_sel (ext_en_sel),
      .en_in   (en_c),
      .ld      (ld_own[c]),
      .err_evt (err_evt[c])
    );

    assign ld_eff[c] = quad_mode ? ld_own[c] : ld_own[0];

    txg_lane_bank #(.LANES(LPC)) u_lanes (
      .clk          (clk),
      .rst_n        (rst_n),
      .div4         (div4_mode),
      .ld           (ld_eff[c]),
      .wide_bytes   (tx_word[c*CH_WIDE +: CH_WIDE]),
      .narrow_bytes (tx_word[c*CH_NARROW +: CH_NARROW]),
      .lane_bits    (tx_lanes[c*LPC +: LPC])
    );
  end

  always_comb begin
    strobe_d = ld_eff;
    err_d    = err_q | (|err_evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= '0;
      err_q    <= 1'b0;
    end else begin
      strobe_q <= strobe_d;
      err_q    <= err_d;
    end
  end

  assign ch_strobe = strobe_q;
  assign align_err = err_q;

  // R9: the error flag never clears outside reset
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |=> align_err);

  // R6: in bus mode every channel strobes together
  p_bus_lockstep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!quad_mode && $past(!quad_mode)) |-> ((&ch_strobe) || !(|ch_strobe)));

  initial begin
    a_width_r2: assert (OUT_W == NCH * LPC && (LPC % 2) == 0);
  end

endmodule

// File: tb/tb_tx_gearbox.sv
`timescale 1ns/1ps
module tb_tx_gearbox;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         div4_mode, quad_mode, ext_en_sel;
  logic [3:0]   ext_load_en;
  logic [127:0] tx_word;
  logic [15:0]  tx_lanes;
  logic [3:0]   ch_strobe;
  logic         align_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  tx_gearbox dut (
    .clk(clk), .rst_n(rst_n), .div4_mode(div4_mode), .quad_mode(quad_mode),
    .ext_en_sel(ext_en_sel), .ext_load_en(ext_load_en), .tx_word(tx_word),
    .tx_lanes(tx_lanes), .ch_strobe(ch_strobe), .align_err(align_err)
  );

  // Reference model state
  int           m_cnt [4];
  int           m_run [4];
  int           m_ph  [4];
  bit           m_val [4];
  logic [127:0] m_w   [4];
  logic [3:0]   m_strb;
  bit           m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_cnt[c] = 0; m_run[c] = 0; m_ph[c] = 0; m_val[c] = 0; m_w[c] = '0;
      end
      m_strb = '0;
      m_err  = 0;
    end else begin
      int  p;
      bit  lo [4];
      p = div4_mode ? 4 : 8;
      for (int c = 0; c < 4; c++) begin
        bit e;
        e = quad_mode ? ext_load_en[c] : ext_load_en[0];
        lo[c] = 0;
        if (ext_en_sel) begin
          if (e) begin
            if (m_run[c] == p - 1) begin
              lo[c] = 1;
              if (m_cnt[c] != p - 1) m_err = 1;
              m_run[c] = 0;
            end else begin
              m_run[c]++;
            end
          end else begin
            if (m_run[c] != 0) m_err = 1;
            m_run[c] = 0;
          end
        end else begin
          m_run[c] = 0;
          lo[c] = (m_cnt[c] == p - 1);
        end
      end
      for (int c = 0; c < 4; c++) begin
        bit le;
        le = quad_mode ? lo[c] : lo[0];
        if (le) begin
          m_w[c] = tx_word; m_ph[c] = 0; m_val[c] = 1; m_strb[c] = 1'b1;
        end else begin
          m_strb[c] = 1'b0;
          if (m_val[c]) m_ph[c]++;
        end
        m_cnt[c] = (lo[c] || m_cnt[c] == p - 1) ? 0 : m_cnt[c] + 1;
      end
    end
  end

  function automatic logic [15:0] exp_lanes();
    logic [15:0] r;
    int p;
    p = div4_mode ? 4 : 8;
    for (int l = 0; l < 16; l++) begin
      int c;
      c = l / 4;
      if (!m_val[c] || m_ph[c] >= p) r[l] = 1'b0;
      else if (!div4_mode) r[l] = m_w[c][8*l + 7 - m_ph[c]];
      else r[l] = m_w[c][8*(l/2) + 7 - 2*m_ph[c] - ((l % 2) ? 0 : 1)];
    end
    return r;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // advance one cycle: wait for the falling edge, compare against the model
  task automatic step();
    @(negedge clk);
    chk(cur_req, "lanes",  32'(tx_lanes),  32'(exp_lanes()));
    chk(cur_req, "strobe", 32'(ch_strobe), 32'(m_strb));
    chk(cur_req, "err",    32'(align_err), 32'(m_err));
  endtask

  task automatic start(input bit d4, input bit q, input bit xs);
    rst_n = 1'b0;
    div4_mode = d4; quad_mode = q; ext_en_sel = xs;
    ext_load_en = '0; tx_word = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset lanes",  32'(tx_lanes),  32'h0);
    chk("R1", "reset strobe", 32'(ch_strobe), 32'h0);
    chk("R1", "reset err",    32'(align_err), 32'h0);
    rst_n = 1'b1;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    rst_n = 1'b0; div4_mode = 0; quad_mode = 0; ext_en_sel = 0;
    ext_load_en = '0; tx_word = '0;

    // Session A: 1:8, bus, internal; data changes every cycle
    cur_req = "R2";
    start(0, 0, 0);
    tx_word = rnd128();
    for (int i = 1; i <= 40; i++) begin
      step();
      if (i == 7)  chk("R1", "no load before edge 8", 32'(ch_strobe), 32'h0);
      if (i == 8)  chk("R1", "first load on edge 8",  32'(ch_strobe), 32'hf);
      if (i == 16 || i == 24) chk("R4", "periodic load", 32'(ch_strobe), 32'hf);
      if (i == 20) chk("R4", "no load mid-word", 32'(ch_strobe), 32'h0);
      tx_word = rnd128();
    end

    // Session B: 1:4, bus, internal; upper half random
    cur_req = "R3";
    start(1, 0, 0);
    tx_word = rnd128();
    for (int i = 1; i <= 40; i++) begin
      step();
      if (i == 4) chk("R1", "first load on edge 4", 32'(ch_strobe), 32'hf);
      tx_word = rnd128();
    end
    // upper 64 bits have no effect: reload with only the upper half set
    for (int i = 0; i < 8; i++) begin
      step();
      tx_word = {64'hFFFF_FFFF_FFFF_FFFF, 64'h0};
    end
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R3", "upper half ignored", 32'(tx_lanes), 32'h0);
    end

    // Session C: 1:8, channel mode, internal
    cur_req = "R5";
    start(0, 1, 0);
    tx_word = rnd128();
    for (int i = 1; i <= 24; i++) begin
      step();
      if (i == 9) chk("R5", "strobe one cycle", 32'(ch_strobe), 32'h0);
      tx_word = rnd128();
    end

    // Session D: 1:4, bus, external; ch0 held high, others toggle
    cur_req = "R6";
    start(1, 0, 1);
    ext_load_en = 4'b0001;
    tx_word = rnd128();
    for (int i = 1; i <= 30; i++) begin
      step();
      if (i == 4 || i == 8) chk("R8", "held enable reloads every 4", 32'(ch_strobe), 32'hf);
      if (i == 6) chk("R8", "no load between", 32'(ch_strobe), 32'h0);
      ext_load_en = {3'($urandom()), 1'b1};
      tx_word = rnd128();
    end
    chk("R6", "no error from ignored enables", 32'(align_err), 32'h0);

    // Session E: 1:8, channel mode, external, independent channels
    cur_req = "R7";
    start(0, 1, 1);
    ext_load_en = 4'b1001;
    tx_word = rnd128();
    for (int i = 1; i <= 40; i++) begin
      step();
      if (i == 8)  chk("R7", "ch0 and ch3 only", 32'(ch_strobe), 32'h9);
      if (i == 16) chk("R7", "ch0 and ch1 only", 32'(ch_strobe), 32'h3);
      if (i == 24) chk("R7", "ch0 ch1 ch3",      32'(ch_strobe), 32'hb);
      if (i == 20) chk("R11", "idle ch2 lanes zero", 32'(tx_lanes[11:8]), 32'h0);
      if (i == 20) chk("R11", "drained ch3 lanes zero", 32'(tx_lanes[15:12]), 32'h0);
      ext_load_en[0] = 1'b1;
      ext_load_en[1] = (i >= 8);
      ext_load_en[2] = 1'b0;
      ext_load_en[3] = ((i / 8) % 2 == 0) || (i >= 16 && i < 24);
      tx_word = rnd128();
    end
    chk("R7", "aligned enables no error", 32'(align_err), 32'h0);

    // Session F: 1:8, bus, external, short pulse
    cur_req = "R9";
    start(0, 0, 1);
    tx_word = rnd128();
    for (int i = 1; i <= 20; i++) begin
      step();
      if (i == 4) chk("R9", "no error while high", 32'(align_err), 32'h0);
      if (i == 5) chk("R9", "error on short fall", 32'(align_err), 32'h1);
      if (i == 20) chk("R9", "error sticky", 32'(align_err), 32'h1);
      if (i >= 5) chk("R9", "no load from short pulse", 32'(tx_lanes), 32'h0);
      ext_load_en = (i >= 1 && i < 4) ? 4'h1 : 4'h0;
      tx_word = rnd128();
    end

    // Session G: 1:4, bus, external misaligned then internal
    cur_req = "R10";
    start(1, 0, 1);
    tx_word = rnd128();
    for (int i = 1; i <= 20; i++) begin
      step();
      if (i == 5)  chk("R10", "no error before load", 32'(align_err), 32'h0);
      if (i == 6)  chk("R10", "misaligned load flagged", 32'(align_err), 32'h1);
      if (i == 6)  chk("R10", "external load", 32'(ch_strobe), 32'hf);
      if (i == 8)  chk("R10", "old phase gone", 32'(ch_strobe), 32'h0);
      if (i == 10 || i == 14) chk("R10", "realigned load", 32'(ch_strobe), 32'hf);
      if (i == 2) ext_load_en = 4'h1;
      if (i == 6) begin ext_load_en = 4'h0; ext_en_sel = 1'b0; end
      tx_word = rnd128();
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    done = 1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule